// File: doc/BRIEF.md
# Chip-Select Gated Serial Command Receiver

This block receives a write-only serial byte stream from a host for a display controller. While the chip select is held low and the mode input selects serial operation, the receiver takes one bit from the serial data line on each rising edge of the serial clock. The most significant bit arrives first. A bit counter tracks the position within the current byte. After the eighth bit, the receiver presents the assembled byte together with a flag that tells display data apart from a command.

All host-side inputs are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and the rising edge of the serial clock is found in the system clock domain. The data/command line is read only on the edge that completes a byte. Releasing chip select throws away any partial byte and restarts the count. A host can therefore resynchronise framing simply by toggling chip select. Bytes can follow one another without deselecting, because the counter wraps.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, `byteValid` is 0, `byteOut` is 0x00 and `isData` is 0.
- R2: While `csN` is 0 and `parSel` is 0, eight rising `scl` edges assemble one byte. The bit taken on the first edge lands in `byteOut[7]` and the bit taken on the last edge lands in `byteOut[0]`.
- R3: `isData` takes the level of `a0` at the eighth rising `scl` edge of a byte (1 = display data, 0 = command). The level of `a0` at the other seven edges has no effect.
- R4: Each completed byte raises `byteValid` for exactly one `clk` cycle. `byteOut` and `isData` then hold their values until the next byte completes.
- R5: The bit counter wraps after eight bits. Consecutive bytes are received without releasing `csN`, and each produces its own strobe.
- R6: Raising `csN` discards any partially received bits. The next byte after reselection is assembled from its own eight bits only.
- R7: `scl` edges that occur while `csN` is 1 are ignored. They produce no strobe, leave the outputs unchanged and do not advance the bit position.
- R8: While `parSel` is 1, the serial path is inactive. No strobe is produced, the outputs hold and any partial byte is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| parSel | input | 1 | Interface select: 0 selects serial reception, 1 disables it |
| csN | input | 1 | Active-low chip select |
| scl | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| a0 | input | 1 | Data/command tag, read on the byte-completing edge |
| byteOut | output | 8 | Last completed byte |
| isData | output | 1 | 1 if the last byte was display data, 0 if it was a command |
| byteValid | output | 1 | One-cycle strobe marking a new byte |

## Verification
A bit counter that is off by one would show as a rotated byte. The strobe would also arrive one serial clock early or late, so the fault appears at the very next byte completion. A shift register that survives deselection would corrupt only the first byte after reselection, so the bench follows each abort with a known byte. A tag sampled at the wrong edge would flip `isData` on the next strobe whenever `a0` changes within a byte. The bench deliberately drives such mid-byte changes.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef struct packed {
    logic clearAll;
    logic shiftEn;
    logic capture;
  } scrStrobe_t;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int WIDTH = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL[b]}};
        else       chain <= {chain[STAGES-2:0], din[b]};
      end
      assign dout[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclS,
  input  logic             csS,
  input  logic             modeS,
  output scrStrobe_t       strobe,
  output logic [CNT_W-1:0] bitCnt,
  output logic             sclRise
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic sclPrev;
  logic active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclPrev <= 1'b0;
    else       sclPrev <= sclS;
  end

  assign sclRise = sclS & ~sclPrev;
  assign active  = ~csS & ~modeS;

  always_comb begin
    strobe.clearAll = ~active;
    strobe.shiftEn  = active & sclRise;
    strobe.capture  = active & sclRise & (bitCnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                bitCnt <= '0;
    else if (strobe.clearAll) bitCnt <= '0;
    else if (strobe.capture)  bitCnt <= '0;
    else if (strobe.shiftEn)  bitCnt <= bitCnt + 1'b1;
  end
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  scrStrobe_t        strobe,
  input  logic              sdiS,
  input  logic              a0S,
  output logic [DATA_W-1:0] byteOut,
  output logic              isData,
  output logic              byteValid
);
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] nextWord;

  assign nextWord = {shReg[DATA_W-2:0], sdiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shReg <= '0;
    else if (strobe.clearAll) shReg <= '0;
    else if (strobe.shiftEn)  shReg <= nextWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteOut   <= '0;
      isData    <= 1'b0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= strobe.capture;
      if (strobe.capture) begin
        byteOut <= nextWord;
        isData  <= a0S;
      end
    end
  end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import scr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              parSel,
  input  logic              csN,
  input  logic              scl,
  input  logic              sdi,
  input  logic              a0,
  output logic [DATA_W-1:0] byteOut,
  output logic              isData,
  output logic              byteValid
);
  logic             modeSync, csSync, sclSync, sdiSync, a0Sync;
  logic             sclRise;
  logic [CNT_W-1:0] bitCnt;
  scrStrobe_t       strobe;

  scr_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11000)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({parSel, csN, scl, sdi, a0}),
    .dout({modeSync, csSync, sclSync, sdiSync, a0Sync})
  );

  scr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclS   (sclSync),
    .csS    (csSync),
    .modeS  (modeSync),
    .strobe (strobe),
    .bitCnt (bitCnt),
    .sclRise(sclRise)
  );

  scr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sdiS     (sdiSync),
    .a0S      (a0Sync),
    .byteOut  (byteOut),
    .isData   (isData),
    .byteValid(byteValid)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteValid,
  input logic [DATA_W-1:0] byteOut,
  input logic              isData,
  input logic [CNT_W-1:0]  bitCnt,
  input logic              csSync,
  input logic              modeSync,
  input logic              sclRise
);
  // R4: strobe lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R4: outputs hold between strobes
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> ($stable(byteOut) && $stable(isData)));

  // R5: each accepted edge advances the position, wrapping
  a_r5_count: assert property (@(posedge clk) disable iff (!rstN)
    (sclRise && !csSync && !modeSync) |=> (bitCnt == CNT_W'($past(bitCnt) + 1'b1)));

  // R2: a strobe coincides with the start of a new byte position
  a_r2_frame: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> (bitCnt == '0));

  // R6: deselect restarts the count
  a_r6_cs_clears: assert property (@(posedge clk) disable iff (!rstN)
    csSync |=> (bitCnt == '0));

  // R7: no strobe while deselected
  a_r7_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    csSync |=> !byteValid);

  // R8: serial path idle in the other mode
  a_r8_mode_idle: assert property (@(posedge clk) disable iff (!rstN)
    modeSync |=> (!byteValid && bitCnt == '0));
endmodule

bind serial_cmd_rx scr_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_serial_cmd_rx.sv
module tb_serial_cmd_rx;
  logic       clk = 1'b0;
  logic       rstN, parSel, csN, scl, sdi, a0;
  logic [7:0] byteOut;
  logic       isData, byteValid;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  int widthErr = 0;
  logic prevValid = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_cmd_rx dut (
    .clk(clk), .rstN(rstN), .parSel(parSel), .csN(csN), .scl(scl),
    .sdi(sdi), .a0(a0), .byteOut(byteOut), .isData(isData), .byteValid(byteValid)
  );

  always @(negedge clk) begin
    if (byteValid) pulseCnt++;
    if (byteValid && prevValid) widthErr++;
    prevValid = byteValid;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input logic tag);
    sdi = b; a0 = tag; scl = 1'b0;
    waitClk(4);
    scl = 1'b1;
    waitClk(5);
    scl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, input logic tag);
    for (int i = 7; i >= 0; i--) sendBit(v[i], tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    int base;
    rstN = 1'b0; parSel = 1'b0; csN = 1'b1; scl = 1'b0; sdi = 1'b0; a0 = 1'b0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(4);
    // R1 reset state
    chk("R1 byteOut", byteOut, 0);
    chk("R1 isData", isData, 0);
    chk("R1 byteValid", byteValid, 0);
    chk("R1 pulses", pulseCnt, 0);

    // R2/R3/R5: streaming sweep of every byte value without deselect
    csN = 1'b0; waitClk(4);
    for (int v = 0; v < 256; v++) begin
      logic tag;
      tag = v[0] ^ v[3];
      base = pulseCnt;
      sendByte(8'(v), tag);
      chk("R2 byte", byteOut, v);
      chk("R3 tag", isData, int'(tag));
      chk("R5 one strobe per byte", pulseCnt - base, 1);
    end
    chk("R4 strobe width", widthErr, 0);
    csN = 1'b1; waitClk(6);

    // R3: tag only at the eighth edge
    csN = 1'b0; waitClk(4);
    for (int i = 7; i >= 1; i--) sendBit(1'b1, 1'b1);
    sendBit(1'b0, 1'b0);
    chk("R3 tag low at last edge", isData, 0);
    chk("R3 byte", byteOut, 8'hFE);
    for (int i = 7; i >= 1; i--) sendBit(1'b0, 1'b0);
    sendBit(1'b1, 1'b1);
    chk("R3 tag high at last edge", isData, 1);
    chk("R3 byte", byteOut, 8'h01);

    // R6: partial byte discarded on deselect
    for (int i = 0; i < 5; i++) sendBit(1'b1, 1'b1);
    csN = 1'b1; waitClk(6);
    csN = 1'b0; waitClk(4);
    base = pulseCnt;
    sendByte(8'h3C, 1'b1);
    chk("R6 byte after abort", byteOut, 8'h3C);
    chk("R6 strobe count", pulseCnt - base, 1);

    // R7: edges while deselected ignored
    csN = 1'b1; waitClk(6);
    base = pulseCnt;
    for (int i = 0; i < 11; i++) sendBit(1'b1, 1'b0);
    chk("R7 no strobe", pulseCnt - base, 0);
    chk("R7 byte held", byteOut, 8'h3C);
    chk("R7 tag held", isData, 1);
    csN = 1'b0; waitClk(4);
    sendByte(8'hA5, 1'b0);
    chk("R7 position not advanced", byteOut, 8'hA5);
    chk("R7 strobe count", pulseCnt - base, 1);

    // R8: serial path inactive with parSel high
    parSel = 1'b1; waitClk(4);
    base = pulseCnt;
    sendByte(8'h5A, 1'b1);
    chk("R8 no strobe", pulseCnt - base, 0);
    chk("R8 byte held", byteOut, 8'hA5);
    sendBit(1'b1, 1'b1); sendBit(1'b1, 1'b1); sendBit(1'b1, 1'b1);
    parSel = 1'b0; waitClk(4);
    sendByte(8'h96, 1'b1);
    chk("R8 partial cleared", byteOut, 8'h96);
    chk("R8 strobe count", pulseCnt - base, 1);

    // R4: outputs hold after strobe
    waitClk(20);
    chk("R4 byte held", byteOut, 8'h96);
    chk("R4 tag held", isData, 1);
    chk("R4 strobe width", widthErr, 0);
    finishRun();
  end
endmodule